// File: doc/BRIEF.md
# Ethernet transmit frame assembler

This block turns a stream of payload bytes from a transmit FIFO into a complete full-duplex Ethernet frame on a 4-bit MII transmit interface. For each frame it sends the preamble and the start-of-frame delimiter. It then takes the payload bytes one at a time and fills short payloads with zero bytes up to the minimum body length. It closes the frame with the complemented CRC-32. After the frame it keeps the line idle for at least the minimum interpacket gap, and stretches that gap when a larger value is requested.

A frame begins when the FIFO offers a byte while the transmitter is idle or its gap has run out. A per-frame flag, sampled at that moment, sends the frame raw: no padding and no check sequence. If the FIFO has no byte ready when the transmitter needs one in the middle of a frame, the frame is cut short. It is closed with a check sequence that is deliberately wrong, the error line is raised over that tail, and a one-cycle underrun pulse is given.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and after its release with no FIFO data offered, mii_en_o, mii_err_o, fifo_ready_o and underrun_o are 0 and mii_d_o is 4'h0.
- R2: Every frame starts with 7 bytes of 0x55 followed by the byte 0xD5. Each byte is sent over two cycles, bits [3:0] on mii_d_o first and bits [7:4] second. mii_en_o is high for every nibble of the frame and for no other cycle.
- R3: A payload byte is taken on a rising edge where fifo_valid_i and fifo_ready_o are both high. fifo_ready_o is high only in the second nibble cycle of the delimiter or of a payload byte that was not marked last, so in an unbroken frame the bytes are taken exactly two cycles apart and sent in the order given.
- R4: Without the raw flag, a payload shorter than 60 bytes is followed by zero bytes until payload plus fill reaches 60 bytes.
- R5: Without the raw flag, the body is followed by four check bytes. They are the bitwise complement of a CRC-32 computed over payload and fill, with polynomial 0x04C11DB7 in reflected form (0xEDB88320), register preset to all ones, data bits taken LSB first. The check value is sent least significant byte first, so a normal frame carries at least 64 bytes after the delimiter.
- R6: A payload of 60 bytes or more gets no fill bytes.
- R7: When fifo_nocrc_i is high as a frame starts, the frame ends right after the byte marked last, with neither fill nor check bytes.
- R8: The idle time between the end of one frame and the start of a frame already waiting is max(ifg_len_i, 24) clock cycles, with ifg_len_i sampled as the frame ends.
- R9: If fifo_valid_i is low while fifo_ready_o is high inside a frame, the frame ends with four bytes equal to the correct check bytes over the data sent so far, with every bit inverted, and no fill. mii_err_o is high on exactly those eight nibbles, and underrun_o pulses for one cycle.
- R10: mii_err_o is never high while mii_en_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_data_i | input | 8 | Payload byte offered by the FIFO |
| fifo_valid_i | input | 1 | FIFO offers a byte |
| fifo_last_i | input | 1 | Offered byte is the last payload byte of the frame |
| fifo_nocrc_i | input | 1 | Raw frame request, sampled when the frame starts |
| fifo_ready_o | output | 1 | Transmitter takes the offered byte on this edge |
| ifg_len_i | input | GAP_W | Requested idle gap in cycles, raised to the floor |
| mii_d_o | output | 4 | Transmit nibble |
| mii_en_o | output | 1 | Transmit enable |
| mii_err_o | output | 1 | Transmit error marker |
| underrun_o | output | 1 | One-cycle pulse when the FIFO runs dry mid-frame |

## Verification
The bench aims at the fill boundary with payloads of 59, 60 and 61 bytes. A design with an off-by-one in its length count sends a wrong frame length there, or folds one fill byte too many into the CRC. It sends raw frames and cuts a frame short mid-payload. A design that pads or adds a check sequence to raw frames, that sends the good check value after an underrun, or that raises the error line too early or leaves it high after the frame, shows a wrong byte or error-marker pattern. Two frames are queued back to back with a requested gap below and above the floor. A transmitter that ignores the floor, or that adds a cycle of idle before starting, shows a measured gap off by that amount.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SFD,
      ST_DATA,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } tx_state_t;

   localparam logic [7:0]  PRE_BYTE   = 8'h55;
   localparam logic [7:0]  SFD_BYTE   = 8'hD5;
   localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
   localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

   // one byte through the reflected CRC-32, LSB of the data first
   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
   import eth_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_i,
   input  logic        upd_i,
   input  logic [7:0]  data_i,
   output logic [31:0] crc_o
);

   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= CRC_PRESET;
      end else if (init_i) begin
         crc_q <= CRC_PRESET;
      end else if (upd_i) begin
         crc_q <= crc32_step(crc_q, data_i);
      end
   end

   assign crc_o = crc_q;

   // R5: each frame's running CRC starts from all ones
   p_crc_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (crc_o == CRC_PRESET));

endmodule

// File: rtl/eth_tx_ifg.sv
module eth_tx_ifg #(
   parameter int GAP_W   = 8,
   parameter int IFG_MIN = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [GAP_W-1:0] len_i,
   output logic             done_o
);

   localparam logic [GAP_W-1:0] FLOOR = GAP_W'(IFG_MIN);

   logic [GAP_W-1:0] target;
   logic [GAP_W-1:0] cnt_q;

   always_comb begin
      target = (len_i < FLOOR) ? FLOOR : len_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= target - GAP_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - GAP_W'(1);
      end
   end

   assign done_o = (cnt_q == '0);

   // R8: a freshly loaded gap never runs shorter than the floor
   p_gap_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q >= FLOOR - GAP_W'(1)));

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
   import eth_tx_pkg::*;
#(
   parameter int PRE_LEN   = 7,
   parameter int MIN_FRAME = 60,
   parameter bit PAD_EN    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  fifo_data_i,
   input  logic        fifo_valid_i,
   input  logic        fifo_last_i,
   input  logic        fifo_nocrc_i,
   output logic        fifo_ready_o,
   input  logic [31:0] crc_i,
   input  logic        gap_done_i,
   output logic        crc_init_o,
   output logic        crc_upd_o,
   output logic [7:0]  crc_byte_o,
   output logic        ifg_load_o,
   output logic [3:0]  mii_d_o,
   output logic        mii_en_o,
   output logic        mii_err_o,
   output logic        underrun_o
);

   localparam int LEN_W = $clog2(MIN_FRAME + 1);
   localparam int CNT_W = $clog2(PRE_LEN + 4);
   localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(MIN_FRAME);
   localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_LEN - 1);

   tx_state_t        state_q, nstate;
   logic [7:0]       byte_q, nbyte;
   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             last_q, nocrc_q, bad_q;
   logic             en_q, err_q, urun_q;
   logic             active, nactive, byte_end, start;
   logic             take, fill, urun, need_pad;
   logic [31:0]      fcs_w;

   // fill decision: a parameter chooses whether short bodies are extended
   if (PAD_EN) begin : g_pad
      assign need_pad = (len_q < LEN_TOP);
   end else begin : g_nopad
      assign need_pad = 1'b0;
   end

   assign active   = (state_q inside {ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS});
   assign nactive  = (nstate  inside {ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS});
   assign byte_end = active && phase_q;
   assign start    = fifo_valid_i &&
                     ((state_q == ST_IDLE) || ((state_q == ST_GAP) && gap_done_i));

   always_comb begin
      nstate = state_q;
      nbyte  = byte_q;
      take   = 1'b0;
      fill   = 1'b0;
      urun   = 1'b0;
      fcs_w  = bad_q ? crc_i : ~crc_i;
      if (start) begin
         nstate = ST_PRE;
         nbyte  = PRE_BYTE;
      end else if (byte_end) begin
         case (state_q)
            ST_PRE: begin
               if (cnt_q == PRE_END) begin
                  nstate = ST_SFD;
                  nbyte  = SFD_BYTE;
               end else begin
                  nbyte = PRE_BYTE;
               end
            end
            ST_SFD, ST_DATA: begin
               if ((state_q == ST_DATA) && last_q) begin
                  if (nocrc_q) begin
                     nstate = ST_GAP;
                  end else if (need_pad) begin
                     nstate = ST_PAD;
                     nbyte  = 8'h00;
                     fill   = 1'b1;
                  end else begin
                     nstate = ST_FCS;
                     nbyte  = ~crc_i[7:0];
                  end
               end else if (fifo_valid_i) begin
                  take   = 1'b1;
                  nstate = ST_DATA;
                  nbyte  = fifo_data_i;
               end else begin
                  // FIFO ran dry: close with the uncomplemented register
                  urun   = 1'b1;
                  nstate = ST_FCS;
                  nbyte  = crc_i[7:0];
               end
            end
            ST_PAD: begin
               if (need_pad) begin
                  nbyte = 8'h00;
                  fill  = 1'b1;
               end else begin
                  nstate = ST_FCS;
                  nbyte  = ~crc_i[7:0];
               end
            end
            ST_FCS: begin
               case (cnt_q[1:0])
                  2'd0:    nbyte = fcs_w[15:8];
                  2'd1:    nbyte = fcs_w[23:16];
                  2'd2:    nbyte = fcs_w[31:24];
                  default: nstate = ST_GAP;
               endcase
            end
            default: ;
         endcase
      end else if ((state_q == ST_GAP) && gap_done_i) begin
         nstate = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         byte_q  <= 8'h00;
         phase_q <= 1'b0;
         cnt_q   <= '0;
         len_q   <= '0;
         last_q  <= 1'b0;
         nocrc_q <= 1'b0;
         bad_q   <= 1'b0;
         en_q    <= 1'b0;
         err_q   <= 1'b0;
         urun_q  <= 1'b0;
      end else begin
         state_q <= nstate;
         byte_q  <= nbyte;
         en_q    <= nactive;
         urun_q  <= urun;
         if (start || byte_end) begin
            phase_q <= 1'b0;
         end else begin
            phase_q <= active;
         end
         if (start) begin
            cnt_q <= '0;
         end else if (byte_end) begin
            cnt_q <= (nstate != state_q) ? '0 : cnt_q + CNT_W'(1);
         end
         if (start) begin
            len_q <= '0;
         end else if ((take || fill) && (len_q < LEN_TOP)) begin
            len_q <= len_q + LEN_W'(1);
         end
         if (start) begin
            last_q  <= 1'b0;
            nocrc_q <= fifo_nocrc_i;
            bad_q   <= 1'b0;
         end else begin
            if (take) last_q <= fifo_last_i;
            if (urun) bad_q  <= 1'b1;
         end
         if (urun) begin
            err_q <= 1'b1;
         end else if (!nactive) begin
            err_q <= 1'b0;
         end
      end
   end

   assign fifo_ready_o = phase_q &&
                         ((state_q == ST_SFD) || ((state_q == ST_DATA) && !last_q));
   assign crc_init_o   = start;
   assign crc_upd_o    = take || fill;
   assign crc_byte_o   = nbyte;
   assign ifg_load_o   = byte_end && (nstate == ST_GAP);
   assign mii_d_o      = en_q ? (phase_q ? byte_q[7:4] : byte_q[3:0]) : 4'h0;
   assign mii_en_o     = en_q;
   assign mii_err_o    = err_q;
   assign underrun_o   = urun_q;

   // R2: the first nibble of any frame is the low half of a preamble byte
   p_pre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_en_o) |-> (mii_d_o == PRE_BYTE[3:0]));

   // R3: a byte is taken at most every other cycle
   p_ready_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ready_o |=> !fifo_ready_o);

   // R3: no byte is taken outside a frame
   p_idle_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mii_en_o |-> !fifo_ready_o);

   // R9: the underrun pulse coincides with the error marker
   p_urun_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> (mii_err_o && mii_en_o));

   // R10: the error marker only rides on an enabled nibble
   p_err_with_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mii_err_o |-> mii_en_o);

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
   import eth_tx_pkg::*;
#(
   parameter int PRE_LEN   = 7,
   parameter int MIN_FRAME = 60,
   parameter bit PAD_EN    = 1'b1,
   parameter int IFG_MIN   = 24,
   parameter int GAP_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       fifo_data_i,
   input  logic             fifo_valid_i,
   input  logic             fifo_last_i,
   input  logic             fifo_nocrc_i,
   output logic             fifo_ready_o,
   input  logic [GAP_W-1:0] ifg_len_i,
   output logic [3:0]       mii_d_o,
   output logic             mii_en_o,
   output logic             mii_err_o,
   output logic             underrun_o
);

   // elaboration-time parameter checks
   if (PRE_LEN < 1 || PRE_LEN > 12) begin : g_bad_pre
      $error("eth_tx_framer: PRE_LEN out of range");
   end
   if (IFG_MIN < 1 || IFG_MIN >= (1 << GAP_W)) begin : g_bad_ifg
      $error("eth_tx_framer: IFG_MIN does not fit GAP_W");
   end
   if (MIN_FRAME < 1 || MIN_FRAME > 4095) begin : g_bad_min
      $error("eth_tx_framer: MIN_FRAME out of range");
   end

   logic [31:0] crc;
   logic        crc_init, crc_upd, ifg_load, gap_done;
   logic [7:0]  crc_byte;

   eth_tx_seq #(
      .PRE_LEN  (PRE_LEN),
      .MIN_FRAME(MIN_FRAME),
      .PAD_EN   (PAD_EN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_data_i (fifo_data_i),
      .fifo_valid_i(fifo_valid_i),
      .fifo_last_i (fifo_last_i),
      .fifo_nocrc_i(fifo_nocrc_i),
      .fifo_ready_o(fifo_ready_o),
      .crc_i       (crc),
      .gap_done_i  (gap_done),
      .crc_init_o  (crc_init),
      .crc_upd_o   (crc_upd),
      .crc_byte_o  (crc_byte),
      .ifg_load_o  (ifg_load),
      .mii_d_o     (mii_d_o),
      .mii_en_o    (mii_en_o),
      .mii_err_o   (mii_err_o),
      .underrun_o  (underrun_o)
   );

   eth_tx_crc u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init_i(crc_init),
      .upd_i (crc_upd),
      .data_i(crc_byte),
      .crc_o (crc)
   );

   eth_tx_ifg #(
      .GAP_W  (GAP_W),
      .IFG_MIN(IFG_MIN)
   ) u_ifg (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(ifg_load),
      .len_i (ifg_len_i),
      .done_o(gap_done)
   );

endmodule

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] fifo_data;
   logic       fifo_valid, fifo_last, fifo_nocrc, fifo_ready;
   logic [7:0] ifg_len;
   logic [3:0] mii_d;
   logic       mii_en, mii_err, underrun;

   always #2.5 clk = ~clk;

   eth_tx_framer u0 (
      .clk(clk), .rst_n(rst_n),
      .fifo_data_i(fifo_data), .fifo_valid_i(fifo_valid),
      .fifo_last_i(fifo_last), .fifo_nocrc_i(fifo_nocrc),
      .fifo_ready_o(fifo_ready), .ifg_len_i(ifg_len),
      .mii_d_o(mii_d), .mii_en_o(mii_en), .mii_err_o(mii_err),
      .underrun_o(underrun)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- output monitor ----------------
   logic [7:0] cap    [0:255];
   bit         cap_er [0:255];
   logic [7:0] exp_b  [0:255];
   bit         exp_er [0:255];
   logic [7:0] pay    [0:255];
   int         acc_log[0:255];
   int cap_len = 0, frames_seen = 0, idle_cnt = 0, last_gap = 0;
   int urun_cnt = 0, er_noen_cnt = 0, acc_n = 0, cyc = 0;
   bit prev_en = 1'b0, nib_hi = 1'b0, lo_er = 1'b0;
   logic [3:0] lo_nib = 4'h0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mii_err && !mii_en) er_noen_cnt++;
         if (underrun) urun_cnt++;
         if (fifo_ready && fifo_valid && acc_n < 256) begin
            acc_log[acc_n] = cyc;
            acc_n++;
         end
         if (mii_en) begin
            if (!prev_en) begin
               cap_len  = 0;
               nib_hi   = 1'b0;
               last_gap = idle_cnt;
            end
            if (!nib_hi) begin
               lo_nib = mii_d;
               lo_er  = mii_err;
               nib_hi = 1'b1;
            end else begin
               if (cap_len < 256) begin
                  cap[cap_len]    = {mii_d, lo_nib};
                  cap_er[cap_len] = lo_er | mii_err;
               end
               cap_len++;
               nib_hi = 1'b0;
            end
            idle_cnt = 0;
         end else begin
            if (prev_en) frames_seen++;
            idle_cnt++;
         end
         prev_en = mii_en;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      bit fb;
      r = c;
      for (int i = 0; i < 8; i++) begin
         fb = r[0] ^ b[i];
         r  = {1'b0, r[31:1]};
         if (fb) r = r ^ 32'hEDB8_8320;
      end
      return r;
   endfunction

   task automatic fill_pay(input int n, input int seed);
      for (int i = 0; i < n; i++) pay[i] = 8'(seed + i * 29 + (i >> 3));
   endtask

   // offers n bytes; only the first stop_at are supplied before valid drops
   task automatic drive(input int n, input int stop_at, input bit nocrc);
      int idx;
      idx = 0;
      @(negedge clk);
      fifo_nocrc = nocrc;
      fifo_valid = 1'b1;
      fifo_data  = pay[0];
      fifo_last  = (n == 1);
      while (idx < stop_at) begin
         @(negedge clk);
         if (fifo_ready) begin
            @(posedge clk);
            #1;
            idx++;
            if (idx < stop_at) begin
               fifo_data = pay[idx];
               fifo_last = (idx == n - 1);
            end else begin
               fifo_valid = 1'b0;
               fifo_last  = 1'b0;
            end
         end
      end
   endtask

   task automatic wait_frames(input int tgt);
      while (frames_seen < tgt) @(negedge clk);
   endtask

   task automatic check_frame(input string req, input int n_sent,
                              input bit nocrc, input bit urun);
      int k, body, bad_pre, bad_body, bad_er, fpos;
      logic [31:0] c;
      k = 0; c = 32'hFFFF_FFFF; body = n_sent;
      for (int i = 0; i < 7; i++) begin exp_b[k] = 8'h55; exp_er[k] = 1'b0; k++; end
      exp_b[k] = 8'hD5; exp_er[k] = 1'b0; k++;
      for (int i = 0; i < n_sent; i++) begin
         exp_b[k] = pay[i]; exp_er[k] = 1'b0; c = ref_crc(c, pay[i]); k++;
      end
      if (urun) begin
         for (int i = 0; i < 4; i++) begin exp_b[k] = c[8*i +: 8]; exp_er[k] = 1'b1; k++; end
      end else if (!nocrc) begin
         while (body < 60) begin
            exp_b[k] = 8'h00; exp_er[k] = 1'b0; c = ref_crc(c, 8'h00); k++; body++;
         end
         for (int i = 0; i < 4; i++) begin exp_b[k] = ~c[8*i +: 8]; exp_er[k] = 1'b0; k++; end
      end
      chk(cap_len == k, req, "frame byte count", cap_len, k);
      bad_pre = 0; bad_body = 0; bad_er = 0; fpos = -1;
      for (int i = 0; i < k && i < cap_len && i < 256; i++) begin
         if (cap[i] !== exp_b[i]) begin
            if (i < 8) bad_pre++; else bad_body++;
            if (fpos < 0) fpos = i;
         end
         if (cap_er[i] != exp_er[i]) bad_er++;
      end
      chk(bad_pre == 0, "R2", "preamble/delimiter mismatches", bad_pre, 0);
      if (fpos >= 0)
         chk(1'b0, req, $sformatf("byte %0d", fpos), cap[fpos], exp_b[fpos]);
      else
         chk(1'b1, req, "body bytes", 0, 0);
      chk(bad_er == 0, urun ? "R9" : "R10", "error-marker byte mismatches", bad_er, 0);
   endtask

   task automatic one_frame(input string req, input int n, input int stop_at,
                            input bit nocrc, input int seed);
      int base;
      fill_pay(n, seed);
      base  = frames_seen;
      acc_n = 0;
      drive(n, stop_at, nocrc);
      wait_frames(base + 1);
      check_frame(req, stop_at, nocrc, stop_at < n);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      rst_n = 1'b0;
      fifo_data = 8'h00; fifo_valid = 1'b0; fifo_last = 1'b0; fifo_nocrc = 1'b0;
      ifg_len = 8'd0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!mii_en && !mii_err, "R1", "en/err in reset", {mii_en, mii_err}, 0);
      chk(!fifo_ready && !underrun, "R1", "ready/underrun in reset", {fifo_ready, underrun}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(mii_d == 4'h0, "R1", "nibble after reset", mii_d, 0);
      chk(!mii_en && !fifo_ready, "R1", "quiet after reset", {mii_en, fifo_ready}, 0);
      chk(!mii_err && !underrun, "R1", "no error after reset", {mii_err, underrun}, 0);
   endtask

   task automatic t_short;
      one_frame("R4 R5", 20, 20, 1'b0, 3);   // 20 bytes, 40 fill, 4 check
   endtask

   task automatic t_boundary;
      one_frame("R4", 59, 59, 1'b0, 11);     // one fill byte
      one_frame("R6", 60, 60, 1'b0, 17);     // exactly at the limit
      one_frame("R6", 61, 61, 1'b0, 23);     // just above
   endtask

   task automatic t_long;
      int off;
      one_frame("R5 R6", 100, 100, 1'b0, 41);
      off = 0;
      for (int i = 1; i < acc_n; i++) if (acc_log[i] - acc_log[i-1] != 2) off++;
      chk(acc_n == 100, "R3", "bytes taken", acc_n, 100);
      chk(off == 0, "R3", "takes not two cycles apart", off, 0);
   endtask

   task automatic t_nocrc;
      one_frame("R7", 10, 10, 1'b1, 55);
      one_frame("R7", 1, 1, 1'b1, 61);
   endtask

   task automatic t_underrun;
      int u0_cnt;
      u0_cnt = urun_cnt;
      one_frame("R9", 30, 12, 1'b0, 77);
      chk(urun_cnt - u0_cnt == 1, "R9", "underrun pulses", urun_cnt - u0_cnt, 1);
      chk(er_noen_cnt == 0, "R10", "error marker without enable", er_noen_cnt, 0);
   endtask

   task automatic t_gap(input int req_len, input int expect_gap);
      int base;
      ifg_len = 8'(req_len);
      fill_pay(6, req_len);
      base = frames_seen;
      drive(6, 6, 1'b0);
      drive(6, 6, 1'b0);
      wait_frames(base + 2);
      chk(last_gap == expect_gap, "R8", $sformatf("gap for request %0d", req_len),
          last_gap, expect_gap);
      check_frame("R8", 6, 1'b0, 1'b0);
   endtask

   // ---------------- watchdog and main ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected all scenarios done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_short();
      t_boundary();
      t_long();
      t_nocrc();
      t_underrun();
      t_gap(10, 24);
      t_gap(40, 40);
      repeat (10) @(negedge clk);
      chk(er_noen_cnt == 0, "R10", "error marker without enable overall", er_noen_cnt, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule